// File: doc/BRIEF.md
# Hex-Digit SIMD Arithmetic Cluster

This block treats each of two 32-bit operands as eight independent 4-bit digits and applies one arithmetic operation to every digit pair at the same time. It can add, subtract or multiply. Each digit result is kept to its low four bits. No carry, borrow or high product bits pass from one digit into the next, so the eight lanes stay fully separate. The cluster sits beside a scalar arithmetic unit as a fast path for digit-wise scrambling steps, such as the multiply-then-add sequence used to mix a key.

The path from operands to result is combinational by default. Setting a parameter adds one output register stage. The block has no flow control: a result is defined in any cycle where the inputs are defined. Control pins are plain levels. When `en` is low, or the select holds its spare code, the result is zero. A downstream mux can therefore OR this result with a scalar result without further gating.

Top module: `nl_simd_cluster`

## Requirements
- R1: With `en`=1 and `op_sel`=2'b00, every result digit at bits [4i+3:4i] equals (A digit + B digit) mod 16, taken from the same bit positions of both operands.
- R2: With `en`=1 and `op_sel`=2'b01, every result digit equals (A digit − B digit) mod 16.
- R3: With `en`=1 and `op_sel`=2'b10, every result digit equals the low 4 bits of (A digit × B digit).
- R4: Lanes are isolated. Changing digit j of either operand leaves every result digit other than j unchanged, for all three operations.
- R5: With `en`=1 and `op_sel`=2'b11, the result is 32'h0.
- R6: With `en`=0, the result is 32'h0 whatever the operands and select are.
- R7: With OUT_REG=0, the result follows the inputs within the same cycle. With OUT_REG=1, the result shows the inputs of the previous rising edge, and it is 32'h0 while `rst_n` is low.
- R8: MUL of 32'h02345432 by 32'hF7421035 gives 32'h0EC8509A. ADD of 32'h0EC8509A and 32'h11111111 gives 32'h1FD961AB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only by the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| en | input | 1 | Cluster enable; when low the result is zero |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 zero |
| opnd_a | input | 32 | First operand, eight 4-bit digits |
| opnd_b | input | 32 | Second operand, eight 4-bit digits |
| result | output | 32 | Packed digit-wise result |

## Verification
The hardest case to expose is a carry or borrow leaking across a lane boundary. A leak shows up only when a digit sum passes 15, a difference goes negative, or a product exceeds 15. The leak must then land in a neighbour whose own result is being watched. The stimulus drives all-F digits, fixed vectors full of overflowing digit pairs, and random operands for each operation. Then, one lane at a time, it flips a single digit of an operand and checks that every other result digit stays the same. A behavioural per-digit model, written with integer arithmetic, gives the expected value for both the combinational and the registered instance.

// File: rtl/nl_pkg.sv
package nl_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_ZERO = 2'b11
  } nl_op_e;

  // one-hot lane control produced by the decoder
  typedef struct packed {
    logic add;
    logic sub;
    logic mul;
  } nl_ctl_t;
endpackage

// File: rtl/nl_lane.sv
module nl_lane
  import nl_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  nl_ctl_t       ctl,
  output logic [DW-1:0] y
);
  logic [DW-1:0] sum_w;
  logic [DW-1:0] dif_w;
  logic [DW-1:0] prd_w;
  logic [DW-1:0] pp  [DW];
  logic [DW-1:0] acc [DW+1];

  // modular add and subtract: the carry out of the top bit is dropped
  assign sum_w = a + b;
  assign dif_w = a - b;

  // shift-and-add multiplier, each partial product already cut to DW bits
  assign acc[0] = '0;
  for (genvar k = 0; k < DW; k++) begin : g_pp
    assign pp[k]    = b[k] ? (a << k) : '0;
    assign acc[k+1] = acc[k] + pp[k];
  end
  assign prd_w = acc[DW];

  assign y = ({DW{ctl.add}} & sum_w)
           | ({DW{ctl.sub}} & dif_w)
           | ({DW{ctl.mul}} & prd_w);
endmodule

// File: rtl/nl_opdec.sv
module nl_opdec
  import nl_pkg::*;
(
  input  logic       en,
  input  logic [1:0] op_sel,
  output nl_ctl_t    ctl
);
  always_comb begin
    ctl = '0;
    if (en) begin
      case (nl_op_e'(op_sel))
        OP_ADD:  ctl.add = 1'b1;
        OP_SUB:  ctl.sub = 1'b1;
        OP_MUL:  ctl.mul = 1'b1;
        default: ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/nl_outstage.sv
module nl_outstage #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_wire
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst_n;
    assign q = d;
  end
endmodule

// File: rtl/nl_simd_cluster.sv
module nl_simd_cluster
  import nl_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int DW      = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [1:0]          op_sel,
  input  logic [LANES*DW-1:0] opnd_a,
  input  logic [LANES*DW-1:0] opnd_b,
  output logic [LANES*DW-1:0] result
);
  localparam int W = LANES * DW;

  nl_ctl_t      ctl;
  logic [W-1:0] lane_y;

  nl_opdec u_dec (
    .en     (en),
    .op_sel (op_sel),
    .ctl    (ctl)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    nl_lane #(.DW(DW)) u_lane (
      .a   (opnd_a[i*DW +: DW]),
      .b   (opnd_b[i*DW +: DW]),
      .ctl (ctl),
      .y   (lane_y[i*DW +: DW])
    );
  end

  nl_outstage #(.W(W), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (lane_y),
    .q     (result)
  );
endmodule

// File: rtl/nl_simd_cluster_chk.sv
module nl_simd_cluster_chk #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [1:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result
);
  if (!OUT_REG) begin : g_comb
    assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> result == '0);
    assert_spare_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_sel == 2'b11) |-> result == '0);
    assert_add_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_sel == 2'b00 && opnd_b == '0) |-> result == opnd_a);
    assert_sub_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_sel == 2'b01 && opnd_a == opnd_b) |-> result == '0);
    assert_mul_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_sel == 2'b10 && opnd_b == '0) |-> result == '0);
  end else begin : g_reg
    assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |-> result == '0);
    assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> result == '0);
    assert_spare_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_sel == 2'b11) |=> result == '0);
    assert_add_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op_sel == 2'b00 && opnd_b == '0) |=> result == $past(opnd_a));
  end
endmodule

bind nl_simd_cluster nl_simd_cluster_chk #(.W(LANES*DW), .OUT_REG(OUT_REG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .result (result)
);

// File: tb/sim_nl_simd_cluster.sv
`timescale 1ns/1ps
module sim_nl_simd_cluster;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] res0, res1;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nl_simd_cluster u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(res0)
  );

  nl_simd_cluster #(.OUT_REG(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(res1)
  );

  // behavioural per-digit model using integer arithmetic
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] op, input logic e);
    logic [31:0] r = '0;
    if (!e) return '0;
    for (int i = 0; i < 8; i++) begin
      int da = int'((a >> (4 * i)) & 32'hF);
      int db = int'((b >> (4 * i)) & 32'hF);
      int v;
      case (op)
        2'b00:   v = (da + db) % 16;
        2'b01:   v = (da - db + 16) % 16;
        2'b10:   v = (da * db) % 16;
        default: v = 0;
      endcase
      r = r | (32'(v) << (4 * i));
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on the falling edge; the combinational result is checked 1 ns later,
  // the registered result 1 ns after the next rising edge
  task automatic run(input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] op, input logic e, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = op; en = e;
    exp = model(a, b, op, e);
    #1 chk({tag, " comb"}, res0, exp);
    @(posedge clk);
    #1 chk({tag, " R7 reg"}, res1, exp);
  endtask

  initial begin
    logic [31:0] ra, rb, y0, msk;
    // reset state
    opnd_a = 32'hFFFFFFFF; opnd_b = 32'hFFFFFFFF; op_sel = 2'b00; en = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R7 reg output under reset", res1, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R8 worked example
    run(32'h02345432, 32'hF7421035, 2'b10, 1'b1, "R8 mul example");
    chk("R8 mul value", res0, 32'h0EC8509A);
    run(32'h0EC8509A, 32'h11111111, 2'b00, 1'b1, "R8 add example");
    chk("R8 add value", res0, 32'h1FD961AB);

    // R1/R2/R3 overflowing digit patterns
    run(32'hFFFFFFFF, 32'h11111111, 2'b00, 1'b1, "R1 add wrap");
    chk("R1 add wrap zero", res0, 32'h0);
    run(32'h00000000, 32'h11111111, 2'b01, 1'b1, "R2 sub borrow");
    chk("R2 sub borrow value", res0, 32'hFFFFFFFF);
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b10, 1'b1, "R3 mul max");
    chk("R3 mul max value", res0, 32'h11111111);
    run(32'h89ABCDEF, 32'h76543210, 2'b01, 1'b1, "R2 sub mixed");

    // R5 spare code, R6 disable
    run(32'hDEADBEEF, 32'h12345678, 2'b11, 1'b1, "R5 spare code");
    for (int op = 0; op < 4; op++)
      run(32'hFFFFFFFF, 32'hEEEEEEEE, 2'(op), 1'b0, "R6 disabled");

    // random operands on every operation
    for (int op = 0; op < 3; op++)
      for (int n = 0; n < 150; n++) begin
        ra = $urandom; rb = $urandom;
        run(ra, rb, 2'(op), 1'b1, op == 0 ? "R1 random" : (op == 1 ? "R2 random" : "R3 random"));
      end

    // R4 lane isolation: flip one digit, other digits must stay put
    for (int op = 0; op < 3; op++)
      for (int j = 0; j < 8; j++) begin
        ra = $urandom | 32'h88888888; rb = $urandom;
        msk = 32'hF << (4 * j);
        run(ra, rb, 2'(op), 1'b1, "R4 base");
        y0 = res0;
        run(ra ^ msk, rb, 2'(op), 1'b1, "R4 flip a");
        chk("R4 isolation a", res0 & ~msk, y0 & ~msk);
        run(ra, rb ^ msk, 2'(op), 1'b1, "R4 flip b");
        chk("R4 isolation b", res0 & ~msk, y0 & ~msk);
      end

    // reset again clears the registered stage
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R7 reg cleared by reset", res1, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule